// File: doc/BRIEF.md
# Descriptor Cache Flush Sequencer with Address Blocking

This block accepts flush commands aimed at a descriptor cache and carries each one out in order. A command names a 40-bit descriptor address along with a small set of control flags. The block can first drain a reorder queue, then issue a flush request to the cache. The request can carry an invalidate qualifier or leave the line valid. After the flush it can lock the flushed address in one of four blocking slots. A single flag switches the command to a whole-cache flush, which locks the entire cache.

A separate unblock input frees one slot or the whole-cache lock. A combinational access-check port tells the cache's other clients whether an address is locked at that moment. Every flush or unblock command ends with a one-cycle status pulse that reports success or error. The block rejects a command that breaks the slot rules, and a rejected command issues no drain and no flush.

The cache array and the queue-drain engine are outside the block. The block sees them only as request/done handshakes.

Top module: `flush_blk_ctrl`

## Requirements
- R1: The command arrives on two inputs. `cmd_addr_lo` holds address bits [31:0]. In `cmd_ctl`, bits [7:0] hold address bits [39:32], bit 8 asks for a queue drain before the flush, bit 9 frees the named slot first, bits [11:10] name the slot, bit 12 keeps the line valid (no invalidate), bit 13 locks the address after the flush, and bit 14 selects a whole-cache flush.
- R2: One command is handled at a time. From acceptance onward, `cmd_ready` and `unblk_ready` stay low until `status_valid` has been high for exactly one cycle. During that cycle `status_err` is 0 for success and 1 for error. Both ready signals return high in the next cycle.
- R3: If the free-slot flag is set and the named slot is not locked, the status is error and neither a drain nor a flush is issued.
- R4: If the lock-after flag is set, the free-slot flag is clear and the named slot is already locked, the status is error, no flush is issued and the slot keeps its address.
- R5: A successful lock-after command stores the flushed address in the named slot. When the free-slot flag is also set, the slot's old address is dropped first. The command succeeds even if the slot was locked.
- R6: When the drain flag is set on an accepted command, `qdrain_req` rises and stays high until `qdrain_done`. `flush_req` rises only after that. `qdrain_req` and `flush_req` are never high together.
- R7: For a non-whole flush, `flush_inval` is the inverse of the keep-valid flag, and `flush_addr` is the command's 40-bit address.
- R8: A whole-cache command issues a flush with `flush_all`=1 and `flush_inval`=1 and ignores every other field, so a free-slot request on an idle slot is not an error. After it completes, every address checks as locked, and the four slots keep their contents.
- R9: An unblock command with `unblk_whole`=1 clears the whole-cache lock. With `unblk_whole`=0 it frees slot `unblk_slot`. If its target is not locked it returns error. It never issues a flush.
- R10: `chk_blocked` is a combinational function of `chk_addr`. It is 1 when the whole-cache lock is set or when a locked slot holds an address equal to `chk_addr` in all 40 bits.
- R11: While `rst_n` is low on a clock edge, all slots and the whole-cache lock are cleared and the sequencer returns to idle, with both ready signals high.
- R12: Once raised, `flush_req` stays high with `flush_addr`, `flush_inval` and `flush_all` unchanged until `flush_done`. When a flush command and an unblock command are offered in the same idle cycle, the unblock is taken and `cmd_ready` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Flush command offered |
| cmd_ready | output | 1 | Flush command can be taken this cycle |
| cmd_addr_lo | input | 32 | Address bits [31:0] |
| cmd_ctl | input | 15 | Upper address byte and control flags (R1) |
| unblk_valid | input | 1 | Unblock command offered |
| unblk_ready | output | 1 | Unblock command can be taken this cycle |
| unblk_whole | input | 1 | 1 clears the whole-cache lock, 0 frees a slot |
| unblk_slot | input | 2 | Slot to free |
| qdrain_req | output | 1 | Queue drain request, held until done |
| qdrain_done | input | 1 | Queue drain finished (one-cycle pulse) |
| flush_req | output | 1 | Flush request to the cache, held until done |
| flush_addr | output | 40 | Address to flush |
| flush_inval | output | 1 | Invalidate the flushed line |
| flush_all | output | 1 | Flush the whole cache |
| flush_done | input | 1 | Flush finished (one-cycle pulse) |
| chk_addr | input | 40 | Address to check for a lock |
| chk_blocked | output | 1 | Queried address or whole cache is locked |
| status_valid | output | 1 | One-cycle command completion pulse |
| status_err | output | 1 | 1 means error, valid with status_valid |

## Verification
The assertions assume that `qdrain_done` and `flush_done` arrive only while the matching request is high and last one cycle. They also assume that a command, once offered, holds its fields until it is taken. The bench's responder pulses a done only after it has seen the request at a falling edge, and then clears it at the next falling edge. Command fields are driven at a falling edge and held until the accepting rising edge. Random addresses come from a small pool so that lock hits, slot reuse and upper-byte-only differences occur often.

// File: rtl/flush_blk_pkg.sv
// Shared definitions for the descriptor cache flush sequencer.
// Assumes a fixed command layout: 32 low address bits on one input and a
// 15-bit control word carrying the upper address byte and the flags.
package flush_blk_pkg;

    localparam int ADDR_W     = 40;
    localparam int LO_W       = 32;
    localparam int HI_W       = ADDR_W - LO_W;
    localparam int SLOT_IDX_W = 2;
    localparam int NUM_SLOTS  = 1 << SLOT_IDX_W;

    // Control word bit positions (the command format fixes them)
    localparam int POS_FWD    = HI_W;
    localparam int POS_REL    = HI_W + 1;
    localparam int POS_SLOT   = HI_W + 2;
    localparam int POS_KEEP   = POS_SLOT + SLOT_IDX_W;
    localparam int POS_BLK    = POS_KEEP + 1;
    localparam int POS_WHOLE  = POS_BLK + 1;
    localparam int CTL_W      = POS_WHOLE + 1;

    typedef struct packed {
        logic [ADDR_W-1:0]     addr;
        logic                  fwd_first;
        logic                  rel_slot;
        logic [SLOT_IDX_W-1:0] slot;
        logic                  keep_valid;
        logic                  blk_after;
        logic                  whole;
    } flush_cmd_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_EVAL,
        SQ_UNBLK,
        SQ_DRAIN,
        SQ_FLUSH,
        SQ_REPLY
    } seq_state_t;

endpackage

// File: rtl/fc_cmd_unpack.sv
// Splits the two command inputs into named fields.
// Purely combinational; assumes the bit positions defined in flush_blk_pkg.
module fc_cmd_unpack
    import flush_blk_pkg::*;
(
    input  logic [LO_W-1:0]  addr_lo,
    input  logic [CTL_W-1:0] ctl,
    output flush_cmd_t       cmd
);

    // Field extraction from the control word
    always_comb begin
        cmd.addr       = {ctl[HI_W-1:0], addr_lo};
        cmd.fwd_first  = ctl[POS_FWD];
        cmd.rel_slot   = ctl[POS_REL];
        cmd.slot       = ctl[POS_SLOT +: SLOT_IDX_W];
        cmd.keep_valid = ctl[POS_KEEP];
        cmd.blk_after  = ctl[POS_BLK];
        cmd.whole      = ctl[POS_WHOLE];
    end

endmodule

// File: rtl/fc_block_slots.sv
// Holds the address-locking slots and the whole-cache lock.
// Answers the access check combinationally. Assumes the sequencer never
// sets and frees the same slot in one cycle (set wins if it did).
module fc_block_slots #(
    parameter int SLOTS  = 4,
    parameter int AW     = 40,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rel_en,
    input  logic [IDX_W-1:0] rel_idx,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [AW-1:0]    set_addr,
    input  logic             whole_set,
    input  logic             whole_clr,
    input  logic [AW-1:0]    chk_addr,
    output logic [SLOTS-1:0] slot_busy,
    output logic             whole_blk,
    output logic             chk_hit
);

    logic [SLOTS-1:0] slot_match;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [AW-1:0] addr_q;

        // Slot state: capture on set, drop on release
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_busy[g] <= 1'b0;
                addr_q       <= '0;
            end else if (set_en && set_idx == IDX_W'(g)) begin
                slot_busy[g] <= 1'b1;
                addr_q       <= set_addr;
            end else if (rel_en && rel_idx == IDX_W'(g)) begin
                slot_busy[g] <= 1'b0;
            end
        end

        // Per-slot address compare for the access check
        always_comb slot_match[g] = slot_busy[g] && (addr_q == chk_addr);
    end

    // Whole-cache lock flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            whole_blk <= 1'b0;
        end else if (whole_set) begin
            whole_blk <= 1'b1;
        end else if (whole_clr) begin
            whole_blk <= 1'b0;
        end
    end

    // Combined access-check result
    always_comb chk_hit = whole_blk || (|slot_match);

endmodule

// File: rtl/fc_flush_seq.sv
// Command sequencer: takes one flush or unblock command at a time, checks
// the slot rules, runs the drain and flush handshakes, updates the slots
// and reports a one-cycle status. Assumes done inputs are single-cycle
// pulses that arrive only while the matching request is high.
module fc_flush_seq
    import flush_blk_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  flush_cmd_t            cmd_in,
    output logic                  cmd_ready,
    input  logic                  unblk_valid,
    input  logic                  unblk_whole,
    input  logic [SLOT_IDX_W-1:0] unblk_slot,
    output logic                  unblk_ready,
    input  logic [NUM_SLOTS-1:0]  slot_busy,
    input  logic                  whole_blk,
    output logic                  rel_en,
    output logic [SLOT_IDX_W-1:0] rel_idx,
    output logic                  set_en,
    output logic [SLOT_IDX_W-1:0] set_idx,
    output logic [ADDR_W-1:0]     set_addr,
    output logic                  whole_set,
    output logic                  whole_clr,
    output logic                  qdrain_req,
    input  logic                  qdrain_done,
    output logic                  flush_req,
    output logic [ADDR_W-1:0]     flush_addr,
    output logic                  flush_inval,
    output logic                  flush_all,
    input  logic                  flush_done,
    output logic                  status_valid,
    output logic                  status_err
);

    seq_state_t            state_q, state_d;
    flush_cmd_t            cmd_q;
    logic                  ub_whole_q;
    logic [SLOT_IDX_W-1:0] ub_slot_q;
    logic                  err_q, err_d, err_ld;
    logic                  take_cmd, take_ub;

    // Acceptance: unblock has priority over flush in the idle state
    always_comb begin
        unblk_ready = (state_q == SQ_IDLE);
        cmd_ready   = (state_q == SQ_IDLE) && !unblk_valid;
        take_ub     = unblk_valid && unblk_ready;
        take_cmd    = cmd_valid && cmd_ready;
    end

    // Next-state, rule checks and slot update strobes
    always_comb begin
        state_d   = state_q;
        err_d     = 1'b0;
        err_ld    = 1'b0;
        rel_en    = 1'b0;
        rel_idx   = cmd_q.slot;
        set_en    = 1'b0;
        whole_set = 1'b0;
        whole_clr = 1'b0;
        unique case (state_q)
            SQ_IDLE: begin
                if (take_ub) begin
                    state_d = SQ_UNBLK;
                end else if (take_cmd) begin
                    state_d = SQ_EVAL;
                end
            end
            SQ_UNBLK: begin
                err_ld  = 1'b1;
                rel_idx = ub_slot_q;
                if (ub_whole_q) begin
                    if (whole_blk) whole_clr = 1'b1;
                    else           err_d     = 1'b1;
                end else begin
                    if (slot_busy[ub_slot_q]) rel_en = 1'b1;
                    else                      err_d  = 1'b1;
                end
                state_d = SQ_REPLY;
            end
            SQ_EVAL: begin
                err_ld = 1'b1;
                if (cmd_q.whole) begin
                    state_d = SQ_FLUSH;
                end else if (cmd_q.rel_slot && !slot_busy[cmd_q.slot]) begin
                    err_d   = 1'b1;
                    state_d = SQ_REPLY;
                end else if (cmd_q.blk_after && !cmd_q.rel_slot &&
                             slot_busy[cmd_q.slot]) begin
                    err_d   = 1'b1;
                    state_d = SQ_REPLY;
                end else begin
                    rel_en  = cmd_q.rel_slot;
                    state_d = cmd_q.fwd_first ? SQ_DRAIN : SQ_FLUSH;
                end
            end
            SQ_DRAIN: begin
                if (qdrain_done) state_d = SQ_FLUSH;
            end
            SQ_FLUSH: begin
                if (flush_done) begin
                    whole_set = cmd_q.whole;
                    set_en    = !cmd_q.whole && cmd_q.blk_after;
                    state_d   = SQ_REPLY;
                end
            end
            SQ_REPLY: begin
                state_d = SQ_IDLE;
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    // State and command capture registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SQ_IDLE;
            cmd_q      <= '0;
            ub_whole_q <= 1'b0;
            ub_slot_q  <= '0;
            err_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take_ub) begin
                ub_whole_q <= unblk_whole;
                ub_slot_q  <= unblk_slot;
            end
            if (take_cmd) cmd_q <= cmd_in;
            if (err_ld)   err_q <= err_d;
        end
    end

    // Handshake and status outputs decoded from the registered state
    always_comb begin
        set_idx      = cmd_q.slot;
        set_addr     = cmd_q.addr;
        qdrain_req   = (state_q == SQ_DRAIN);
        flush_req    = (state_q == SQ_FLUSH);
        flush_all    = cmd_q.whole;
        flush_inval  = cmd_q.whole || !cmd_q.keep_valid;
        flush_addr   = cmd_q.whole ? '0 : cmd_q.addr;
        status_valid = (state_q == SQ_REPLY);
        status_err   = err_q;
    end

endmodule

// File: rtl/flush_blk_ctrl.sv
// Top level of the descriptor cache flush sequencer. Joins the command
// unpacker, the sequencer and the slot table. Assumes a single clock and
// a synchronous active-low reset.
module flush_blk_ctrl
    import flush_blk_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    output logic                  cmd_ready,
    input  logic [LO_W-1:0]       cmd_addr_lo,
    input  logic [CTL_W-1:0]      cmd_ctl,
    input  logic                  unblk_valid,
    output logic                  unblk_ready,
    input  logic                  unblk_whole,
    input  logic [SLOT_IDX_W-1:0] unblk_slot,
    output logic                  qdrain_req,
    input  logic                  qdrain_done,
    output logic                  flush_req,
    output logic [ADDR_W-1:0]     flush_addr,
    output logic                  flush_inval,
    output logic                  flush_all,
    input  logic                  flush_done,
    input  logic [ADDR_W-1:0]     chk_addr,
    output logic                  chk_blocked,
    output logic                  status_valid,
    output logic                  status_err
);

    flush_cmd_t            cmd_dec;
    logic [NUM_SLOTS-1:0]  slot_busy;
    logic                  whole_blk;
    logic                  rel_en, set_en, whole_set, whole_clr;
    logic [SLOT_IDX_W-1:0] rel_idx, set_idx;
    logic [ADDR_W-1:0]     set_addr;

    fc_cmd_unpack u_unpack (
        .addr_lo (cmd_addr_lo),
        .ctl     (cmd_ctl),
        .cmd     (cmd_dec)
    );

    fc_flush_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_in       (cmd_dec),
        .cmd_ready    (cmd_ready),
        .unblk_valid  (unblk_valid),
        .unblk_whole  (unblk_whole),
        .unblk_slot   (unblk_slot),
        .unblk_ready  (unblk_ready),
        .slot_busy    (slot_busy),
        .whole_blk    (whole_blk),
        .rel_en       (rel_en),
        .rel_idx      (rel_idx),
        .set_en       (set_en),
        .set_idx      (set_idx),
        .set_addr     (set_addr),
        .whole_set    (whole_set),
        .whole_clr    (whole_clr),
        .qdrain_req   (qdrain_req),
        .qdrain_done  (qdrain_done),
        .flush_req    (flush_req),
        .flush_addr   (flush_addr),
        .flush_inval  (flush_inval),
        .flush_all    (flush_all),
        .flush_done   (flush_done),
        .status_valid (status_valid),
        .status_err   (status_err)
    );

    fc_block_slots #(
        .SLOTS (NUM_SLOTS),
        .AW    (ADDR_W)
    ) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .rel_en    (rel_en),
        .rel_idx   (rel_idx),
        .set_en    (set_en),
        .set_idx   (set_idx),
        .set_addr  (set_addr),
        .whole_set (whole_set),
        .whole_clr (whole_clr),
        .chk_addr  (chk_addr),
        .slot_busy (slot_busy),
        .whole_blk (whole_blk),
        .chk_hit   (chk_blocked)
    );

endmodule

// File: rtl/flush_blk_ctrl_chk.sv
// Protocol checker for flush_blk_ctrl, bound to its ports.
// Assumes done pulses arrive only while the matching request is high.
module flush_blk_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic        unblk_valid,
    input logic        unblk_ready,
    input logic        qdrain_req,
    input logic        qdrain_done,
    input logic        flush_req,
    input logic [39:0] flush_addr,
    input logic        flush_inval,
    input logic        flush_all,
    input logic        flush_done,
    input logic        chk_blocked,
    input logic        status_valid
);

    logic was_rst;

    // Remembers that the previous edge saw reset
    always_ff @(posedge clk) was_rst <= !rst_n;

    // R2
    one_cmd_at_a_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_valid && cmd_ready) || (unblk_valid && unblk_ready))
        |=> (!cmd_ready && !unblk_ready));

    // R2
    status_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_valid |=> !status_valid);

    // R2
    idle_after_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_valid |=> unblk_ready);

    // R6
    drain_flush_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(qdrain_req && flush_req));

    // R6
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qdrain_req && !qdrain_done) |=> qdrain_req);

    // R12
    flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !flush_done) |=> (flush_req && $stable(flush_addr) &&
                                        $stable(flush_inval) && $stable(flush_all)));

    // R8
    whole_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && flush_all && flush_done) |=> chk_blocked);

    // Sampled state on the first edge after reset
    always @(posedge clk) begin
        if (rst_n && was_rst) begin
            // R11
            reset_state_chk: assert (!chk_blocked && unblk_ready && !flush_req &&
                                     !qdrain_req && !status_valid)
                else $error("state not cleared by reset");
        end
    end

endmodule

bind flush_blk_ctrl flush_blk_ctrl_chk u_chk (.*);

// File: tb/test_flush_blk_ctrl.sv
module test_flush_blk_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_addr_lo = '0;
    logic [14:0] cmd_ctl = '0;
    logic        unblk_valid = 1'b0;
    logic        unblk_ready;
    logic        unblk_whole = 1'b0;
    logic [1:0]  unblk_slot = '0;
    logic        qdrain_req;
    logic        qdrain_done = 1'b0;
    logic        flush_req;
    logic [39:0] flush_addr;
    logic        flush_inval;
    logic        flush_all;
    logic        flush_done = 1'b0;
    logic [39:0] chk_addr = '0;
    logic        chk_blocked;
    logic        status_valid;
    logic        status_err;

    int n_chk = 0;
    int n_fail = 0;

    bit          m_busy [4];
    logic [39:0] m_addr [4];
    bit          m_whole;
    logic [39:0] pool [6];

    // reply observations
    bit          r_err, r_drain, r_flush, r_order_ok, r_inv, r_all, r_busy_ok;
    logic [39:0] r_addr;

    always #2 clk = ~clk;

    flush_blk_ctrl i_flush_blk_ctrl (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_blocked(input logic [39:0] a);
        bit hit = m_whole;
        for (int i = 0; i < 4; i++) if (m_busy[i] && m_addr[i] == a) hit = 1;
        return hit;
    endfunction

    task automatic sweep(input string req);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk_addr = pool[i];
            #1;
            check(chk_blocked == exp_blocked(pool[i]), req, "chk_blocked",
                  chk_blocked, exp_blocked(pool[i]));
        end
    endtask

    task automatic wait_reply(input bit exp_fwd);
        int  dly = int'($urandom % 3);
        int  guard = 0;
        bit  drained = 0;
        r_drain = 0; r_flush = 0; r_order_ok = 1; r_err = 0; r_busy_ok = 1;
        forever begin
            @(negedge clk);
            qdrain_done = 1'b0;
            flush_done  = 1'b0;
            guard++;
            if (guard > 300) begin
                check(0, "R2", "no status pulse", 0, 1);
                break;
            end
            if (status_valid) begin
                r_err = status_err;
                r_busy_ok = !cmd_ready && !unblk_ready;
                break;
            end
            if (qdrain_req) begin
                r_drain = 1;
                if (dly == 0) begin
                    qdrain_done = 1'b1;
                    drained = 1;
                    dly = int'($urandom % 3);
                end else dly--;
            end else if (flush_req) begin
                if (!r_flush) begin
                    r_flush = 1;
                    r_order_ok = !exp_fwd || drained;
                    r_addr = flush_addr;
                    r_inv = flush_inval;
                    r_all = flush_all;
                end
                if (dly == 0) begin
                    flush_done = 1'b1;
                    dly = int'($urandom % 3);
                end else dly--;
            end
        end
        check(r_busy_ok, "R2", "ready low during status", r_busy_ok, 1);
        @(negedge clk);
        check(cmd_ready && unblk_ready, "R2", "ready after status",
              {cmd_ready, unblk_ready}, 2'b11);
    endtask

    task automatic send_cmd(input logic [39:0] a, input bit fwd, input bit rel,
                            input logic [1:0] slot, input bit keep, input bit blk,
                            input bit whole);
        bit e_err = 0, e_flush = 0, e_drain = 0, e_inv = 0;
        string tag;
        if (whole) begin
            e_flush = 1; e_inv = 1; tag = "R8";
        end else if (rel && !m_busy[slot]) begin
            e_err = 1; tag = "R3";
        end else if (blk && !rel && m_busy[slot]) begin
            e_err = 1; tag = "R4";
        end else begin
            e_flush = 1; e_drain = fwd; e_inv = !keep; tag = blk ? "R5" : "R7";
        end
        @(negedge clk);
        cmd_valid   = 1'b1;
        cmd_addr_lo = a[31:0];
        cmd_ctl     = {whole, blk, keep, slot, rel, fwd, a[39:32]};
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        #1 cmd_valid = 1'b0;
        wait_reply(fwd && !whole);
        check(r_err == e_err, tag, "status_err", r_err, e_err);
        check(r_flush == e_flush, tag, "flush issued", r_flush, e_flush);
        check(r_drain == e_drain, "R6", "drain issued", r_drain, e_drain);
        if (e_flush) begin
            check(r_order_ok, "R6", "drain before flush", r_order_ok, 1);
            check(r_inv == e_inv, "R7", "flush_inval", r_inv, e_inv);
            check(r_all == whole, "R8", "flush_all", r_all, whole);
            if (!whole) check(r_addr == a, "R1", "flush_addr", r_addr, a);
        end
        if (whole) m_whole = 1;
        else if (!e_err) begin
            if (rel) m_busy[slot] = 0;
            if (blk) begin
                m_busy[slot] = 1;
                m_addr[slot] = a;
            end
        end
        sweep(blk ? "R5" : "R10");
    endtask

    task automatic send_unblk(input bit whole, input logic [1:0] slot, input bit with_cmd);
        bit e_err = whole ? !m_whole : !m_busy[slot];
        @(negedge clk);
        unblk_valid = 1'b1;
        unblk_whole = whole;
        unblk_slot  = slot;
        if (with_cmd) begin
            cmd_valid = 1'b1;
            #1;
            check(!cmd_ready && unblk_ready, "R12", "unblock priority",
                  {cmd_ready, unblk_ready}, 2'b01);
            cmd_valid = 1'b0;
        end
        while (!unblk_ready) @(negedge clk);
        @(posedge clk);
        #1 unblk_valid = 1'b0;
        wait_reply(0);
        check(r_err == e_err, "R9", "unblock status_err", r_err, e_err);
        check(!r_flush && !r_drain, "R9", "unblock issued no flush", r_flush, 0);
        if (whole) m_whole = 0;
        else m_busy[slot] = 0;
        sweep("R9");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_whole = 0;
        for (int i = 0; i < 4; i++) begin
            m_busy[i] = 0;
            m_addr[i] = '0;
        end
        #1;
        check(cmd_ready && unblk_ready, "R11", "ready after reset",
              {cmd_ready, unblk_ready}, 2'b11);
        check(!flush_req && !qdrain_req && !status_valid, "R11", "outputs idle",
              {flush_req, qdrain_req, status_valid}, 0);
        sweep("R11");
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Main sequence
    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 5; i++) pool[i] = 40'hA5_1000_0000 + 40'(i * 64);
        pool[5] = {8'h5A, pool[1][31:0]};
        do_reset();

        send_cmd(pool[2], 0, 1, 2'd1, 0, 0, 0);   // R3 release of a free slot
        send_cmd(pool[0], 1, 0, 2'd0, 0, 1, 0);   // R5 lock with drain
        send_cmd(pool[1], 0, 0, 2'd0, 0, 1, 0);   // R4 slot already locked
        send_cmd(pool[1], 0, 1, 2'd0, 0, 1, 0);   // R5 release then relock
        send_cmd(pool[5], 0, 0, 2'd2, 1, 0, 0);   // R7 keep valid, R1 upper byte
        send_cmd(pool[3], 1, 1, 2'd3, 1, 1, 1);   // R8 whole, other fields ignored
        send_unblk(1, 2'd0, 0);                   // R9 clear whole, slot 0 kept
        send_unblk(1, 2'd0, 0);                   // R9 whole not locked
        send_unblk(0, 2'd3, 0);                   // R9 slot not locked
        send_unblk(0, 2'd0, 1);                   // R12 priority, R9 frees slot 0

        for (int n = 0; n < 250; n++) begin
            logic [31:0] r = $urandom;
            if (r[2:0] < 2)
                send_unblk(r[3], r[5:4], 0);
            else
                send_cmd(pool[$urandom % 6], r[8], r[9], r[11:10], r[12],
                         r[13], r[16:14] == 3'd0);
            if (n == 150) do_reset();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule